// File: doc/BRIEF.md
# Fall-Through Marker-Bit FIFO

This block is an elastic first-in first-out buffer built as a chain of word positions. Each position holds one data word and a marker bit that says whether the word is valid. A word written at the input end moves one position per clock toward the output end whenever the position ahead of it is empty. Empty slots therefore drift back toward the input, and valid words collect at the output. No read or write pointers exist. The two status flags are the marker of the first position (inverted) and the marker of the last position.

A producer places a word on `data_in` and raises `shift_in`. A consumer watches `out_ready`, takes `data_out`, and lowers `shift_out` to discard that word. All strobes are synchronous to `clk` and are turned into edge events inside the block. `out_off` disables the output: the data bus reads zero, the enable flag drops, and unloading is blocked. `mclr` marks every position empty but leaves the stored words in place.

Top module: `bubble_fifo`

## Requirements
- R1: Depth (`DEPTH`, default 16) and word width (`WIDTH`, default 4) are parameters. In the default geometry, a word written into an empty FIFO reaches the output.
- R2: `mclr` is a synchronous, active-high clear. At the clock edge where it is high, every marker is cleared: afterwards `in_ready`=1 and `out_ready`=0. The stored words are not changed, so `data_out` still shows the old last-position word.
- R3: A rising edge of shift-in is `shift_in`=1 in this cycle and 0 in the previous one. Such an edge while `in_ready`=1 stores `data_in` in the first position. In the following cycle `in_ready` is 0.
- R4: Shift-in is edge-triggered. Holding `shift_in` high stores only one word, and rising edges that arrive while `in_ready`=0 are ignored.
- R5: A word moves at most one position per clock. A word accepted at clock edge k into an empty FIFO makes `out_ready` go high after edge k+DEPTH-1, and not before.
- R6: Words leave in the order they entered. The FIFO holds exactly DEPTH words. Once it is full and has settled, `in_ready` stays 0.
- R7: A falling edge of shift-out is `shift_out`=0 in this cycle and 1 in the previous one. Such an edge while `out_ready`=1 and `out_off`=0 discards the output word, and `out_ready` is 0 in the next cycle. If the second-to-last position is full, the next word is at the output one cycle later.
- R8: When the FIFO is empty, falling edges of shift-out have no effect. A word written afterwards still arrives intact.
- R9: While `out_off`=1, `data_out` is all zeros, `data_out_en`=0 and unloading is blocked. A shift-out edge seen while disabled is dropped and is not replayed when the output is enabled again.
- R10: `shift_in` must be low in any cycle where `mclr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| mclr | input | 1 | Synchronous clear of all markers, active high |
| shift_in | input | 1 | Write strobe; its rising edge stores `data_in` |
| data_in | input | WIDTH | Word to store |
| shift_out | input | 1 | Read strobe; its falling edge discards the output word |
| out_off | input | 1 | High disables the output and blocks unloading |
| in_ready | output | 1 | First position is empty |
| out_ready | output | 1 | Last position holds a valid word |
| data_out | output | WIDTH | Word in the last position, zero while disabled |
| data_out_en | output | 1 | High when `data_out` is driven |

## Verification
The bench builds a 4-deep, 4-bit instance so that every fill level from empty to full can be swept. Each of the 16 data values passes through that instance and is compared against a queue model. A second instance with the default 16x4 geometry shares the same inputs. The bench uses it to time the full ripple from input to output against DEPTH-1 clocks, which the short instance cannot show at full length.

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             mclr,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  input  logic             shift_out,
  input  logic             out_off,
  output logic             in_ready,
  output logic             out_ready,
  output logic [WIDTH-1:0] data_out,
  output logic             data_out_en
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] mk;
  logic [DEPTH-1:0] mk_nx;
  logic [DEPTH-1:0] mv;
  logic [WIDTH-1:0] wd [DEPTH];
  logic             si_q;
  logic             so_q;
  logic             take;
  logic             drop;

  assign take = shift_in & ~si_q & ~mk[0];
  assign drop = ~shift_out & so_q & mk[LAST] & ~out_off;

  assign mv[0] = take;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i > 0) begin : g_mv
      assign mv[i] = mk[i-1] & ~mk[i];
    end
    if (i < LAST) begin : g_mid
      assign mk_nx[i] = mv[i] | (mk[i] & ~mv[i+1]);
    end else begin : g_end
      assign mk_nx[i] = mv[i] | (mk[i] & ~drop);
    end
    if (i == 0) begin : g_head
      always_ff @(posedge clk)
        if (!mclr && mv[i]) wd[i] <= data_in;
    end else begin : g_body
      always_ff @(posedge clk)
        if (!mclr && mv[i]) wd[i] <= wd[i-1];
    end
  end

  always_ff @(posedge clk) begin
    si_q <= shift_in;
    so_q <= shift_out;
    if (mclr) mk <= '0;
    else      mk <= mk_nx;
  end

  assign in_ready    = ~mk[0];
  assign out_ready   = mk[LAST];
  assign data_out_en = ~out_off;
  assign data_out    = out_off ? '0 : wd[LAST];

  always @(posedge clk)
    if (mclr) AST_SI_LOW_IN_CLEAR: assert (!shift_in); // R10

  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (mclr)
    take |=> !in_ready); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (mclr)
    (&mk) |=> !in_ready); // R6

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (mclr)
    drop |=> !out_ready); // R7

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (mclr)
    (out_ready && !drop) |=> (out_ready && $stable(wd[LAST]))); // R7

  AST_OFF_BLOCKS: assert property (@(posedge clk) disable iff (mclr)
    (out_off && out_ready) |=> out_ready); // R9

endmodule

// File: tb/bubble_fifo_tb.sv
module bubble_fifo_tb;
  localparam int CLK_NS = 10;
  localparam int D  = 4;
  localparam int W  = 4;
  localparam int DL = 16;

  logic clk = 0, mclr = 1, shift_in = 0, shift_out = 1, out_off = 0;
  logic [W-1:0] data_in = '0;
  logic in_rdy, out_rdy, dout_en, in_rdy16, out_rdy16, dout_en16;
  logic [W-1:0] dout, dout16;

  bubble_fifo #(.DEPTH(D), .WIDTH(W)) u_dut (
    .clk(clk), .mclr(mclr), .shift_in(shift_in), .data_in(data_in),
    .shift_out(shift_out), .out_off(out_off), .in_ready(in_rdy),
    .out_ready(out_rdy), .data_out(dout), .data_out_en(dout_en));

  bubble_fifo u_dut16 (
    .clk(clk), .mclr(mclr), .shift_in(shift_in), .data_in(data_in),
    .shift_out(shift_out), .out_off(out_off), .in_ready(in_rdy16),
    .out_ready(out_rdy16), .data_out(dout16), .data_out_en(dout_en16));

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] q[$];

  task automatic tick; @(negedge clk); endtask

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle; repeat (D + 2) tick; endtask

  task automatic push(input logic [W-1:0] v);
    for (int g = 0; g < 50 && !in_rdy; g++) tick;
    data_in = v; shift_in = 1; tick;
    check(in_rdy, 0, "R3 in_ready low after accept");
    shift_in = 0; tick;
    q.push_back(v);
  endtask

  task automatic pop;
    int e;
    for (int g = 0; g < 50 && !out_rdy; g++) tick;
    check(out_rdy, 1, "R6 word present");
    e = (q.size() > 0) ? int'(q.pop_front()) : -1;
    check(dout, e, "R6 order");
    shift_out = 0; tick;
    check(out_rdy, 0, "R7 out_ready low after unload");
    shift_out = 1; tick;
  endtask

  task automatic do_clear;
    mclr = 1; repeat (2) tick; mclr = 0; tick;
    q.delete();
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    mclr = 0; tick;
    check(in_rdy, 1, "R2 in_ready after clear");
    check(out_rdy, 0, "R2 out_ready after clear");

    // R5 / R1: ripple latency in both geometries
    data_in = 4'd9; shift_in = 1;
    for (int k = 1; k <= DL; k++) begin
      tick;
      if (k == 1) shift_in = 0;
      if (k == D - 1) check(out_rdy, 0, "R5 early small");
      if (k == D)     check(out_rdy, 1, "R5 arrival small");
      if (k == DL - 1) check(out_rdy16, 0, "R1 early default");
      if (k == DL) begin
        check(out_rdy16, 1, "R1 arrival default");
        check(dout16, 9, "R1 word default");
      end
    end

    // R2: clear keeps stored data
    do_clear;
    check(out_rdy, 0, "R2 markers cleared");
    check(in_rdy, 1, "R2 input free");
    check(dout, 9, "R2 data unchanged");

    // R6 / R4: sweep fill levels
    for (int n = 0; n <= D; n++) begin
      for (int i = 0; i < n; i++) push(W'((n * 7 + i * 3 + 1) & 15));
      settle;
      check(in_rdy, (n < D) ? 1 : 0, "R6 in_ready vs fill");
      check(out_rdy, (n > 0) ? 1 : 0, "R6 out_ready vs fill");
      if (n == D) begin
        data_in = 4'hF; shift_in = 1; tick; shift_in = 0; tick;
        check(in_rdy, 0, "R4 full stays full");
      end
      for (int i = 0; i < n; i++) pop;
      settle;
      check(out_rdy, 0, "R4 nothing extra stored");
    end

    // all data values through the FIFO
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < D; i++) push(W'(b * 4 + i));
      for (int i = 0; i < D; i++) pop;
    end

    // R8: unload on empty ignored
    settle;
    shift_out = 0; tick; shift_out = 1; tick;
    check(out_rdy, 0, "R8 empty stays empty");
    push(4'hA); settle;
    check(out_rdy, 1, "R8 word arrives after empty unload");
    pop;

    // R4: held strobe accepts one word
    data_in = 4'd3; shift_in = 1; tick;
    data_in = 4'd5; repeat (5) tick;
    shift_in = 0; q.push_back(4'd3); settle;
    check(dout, 3, "R4 held strobe word");
    pop; settle;
    check(out_rdy, 0, "R4 held strobe single word");

    // R7: back-to-back advance
    push(4'd1); push(4'd2); settle;
    pop;
    check(out_rdy, 1, "R7 next word ready");
    check(dout, 2, "R7 next word value");
    pop;

    // R9: disabled output
    push(4'd6); settle;
    out_off = 1; tick;
    check(dout, 0, "R9 data zero when off");
    check(dout_en, 0, "R9 enable low when off");
    shift_out = 0; tick; shift_out = 1; tick;
    check(out_rdy, 1, "R9 unload blocked");
    out_off = 0; tick;
    check(dout, 6, "R9 word kept");
    check(dout_en, 1, "R9 enable high");
    out_off = 1; shift_out = 0; tick;
    out_off = 0; tick;
    check(out_rdy, 1, "R9 edge not replayed");
    shift_out = 1; tick;
    pop;

    // R2: clear with several words inside
    push(4'd4); push(4'd8); push(4'd12); settle;
    do_clear;
    check(out_rdy, 0, "R2 clear drops words");
    check(in_rdy, 1, "R2 clear frees input");
    push(4'd7); settle;
    pop;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule